// File: doc/BRIEF.md
# Masked Register Broadcast Engine

This block carries out one broadcast instruction at a time. A single operation, with a single source register as its operand, is applied to each register picked out by a 16-bit destination mask in a bank of sixteen 32-bit registers. The engine latches the decoded instruction word when a start strobe arrives. It reads the source register once, then walks the selected bank from index 0 upward. At each step it reads the current register, combines it with the latched source value, and writes the result back if the mask bit for that index is set.

The supported operations are moves and two-operand arithmetic and logic, signed minimum and maximum, three kinds of multiply, absolute value, a shift and a rotate whose signed amount sets the direction, and three compares that write all-ones or zero. The register file is outside the block. The engine drives a read port with a bank select and an index, and takes the read data back in the same cycle. It drives a write port with an enable, a bank select, an index and the data. A busy level and a one-cycle done pulse tell the issuing logic when the instruction has finished.

Top module: `mask_bcast_unit`

## Requirements
- R1: An instruction word is accepted only when bit 31 is 1, bit 30 is 0, bits [29:28] are 0 and the opcode in bits [26:20] is one of 1–6, 13, 14 or 17–25. Any other word completes one edge after start with `illegal` and `done` high for one cycle, and with no register write.
- R2: Opcodes 1–6 write, in order, src, dst+src, dst−src, dst&src, dst|src and dst^src. Sums and differences wrap modulo 2^32.
- R3: Opcode 13 writes the signed minimum of dst and src. Opcode 14 writes the signed maximum.
- R4: Opcode 17 writes the low 32 bits of dst×src. Opcode 18 writes the high 32 bits of the unsigned 64-bit product. Opcode 19 writes the high 32 bits of the signed 64-bit product.
- R5: Opcode 20 writes the absolute value of dst and ignores src. The most negative value stays unchanged.
- R6: Opcode 21 is a logical shift of dst by the signed value of src. A positive amount shifts left and a negative amount shifts right. An amount of magnitude 32 or more gives zero.
- R7: Opcode 22 rotates dst by the signed value of src. A positive amount rotates left and a negative amount rotates right, so the result equals a left rotate by src modulo 32.
- R8: Opcodes 23, 24 and 25 write 0xFFFFFFFF when dst equals src, when dst is signed-less-than src, and when dst is signed-greater-than src, respectively. Otherwise they write 0.
- R9: Mask bit i (bits [15:0]) selects register i. A register whose bit is clear is never written. Bit 27 picks the destination bank (1 = address bank, 0 = data bank). The source index is bits [19:16] and always refers to the data bank.
- R10: A legal instruction with an all-zero mask raises `done` one edge after start, performs no read of the source and no write, and leaves `illegal` low.
- R11: The source value is captured once before the walk starts. A source register that is also selected does not change the operand used for later registers.
- R12: Counting the edge that samples `start` as edge 1, the write for register i happens at edge i+3. `done` pulses for one cycle at the edge of the highest selected register. `busy` stays high from edge 1 until `done` and is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `instr` while idle |
| instr | input | 32 | Broadcast instruction word |
| rd_sel | output | 1 | Read bank select, 1 = address bank |
| rd_idx | output | 4 | Read register index |
| rd_data | input | 32 | Read data for `rd_sel`/`rd_idx`, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 1 | Write bank select, 1 = address bank |
| wr_idx | output | 4 | Write register index |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection flag, set together with `done` |

## Verification
On every cycle, the assertions check that no write ever reaches an unselected register, that write indices climb by one across back-to-back writes, and that a compare only ever writes all-ones or zero. They also check that `done` is a single pulse, that it never overlaps `busy`, and that a rejected or zero-mask instruction ends at once without a write. The numeric result of each operation and the signed edge cases cannot be seen by those properties. The same holds for the source being captured before a self-overlapping walk, for the destination bank select, and for the exact edge on which `done` arrives. Only the bench's vector table and directed scenarios show these.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

  typedef enum logic [6:0] {
    OP_MOV    = 7'd1,
    OP_ADD    = 7'd2,
    OP_SUB    = 7'd3,
    OP_AND    = 7'd4,
    OP_OR     = 7'd5,
    OP_XOR    = 7'd6,
    OP_MIN    = 7'd13,
    OP_MAX    = 7'd14,
    OP_MUL    = 7'd17,
    OP_MULHU  = 7'd18,
    OP_MULHS  = 7'd19,
    OP_ABS    = 7'd20,
    OP_SHIFT  = 7'd21,
    OP_ROT    = 7'd22,
    OP_CMPEQ  = 7'd23,
    OP_CMPLT  = 7'd24,
    OP_CMPGT  = 7'd25
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_WALK = 2'd2
  } bst_e;

endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
  import bcast_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [31:0]      instr,
  output logic             legal,
  output bop_e             op,
  output logic             dst_addr,
  output logic [IDX_W-1:0] src_idx,
  output logic [NREG-1:0]  mask,
  output logic             mask_zero,
  output logic [IDX_W-1:0] last_idx
);

  logic fmt_ok;
  logic op_ok;

  assign op       = bop_e'(instr[26:20]);
  assign dst_addr = instr[27];
  assign src_idx  = instr[16 +: IDX_W];
  assign mask     = instr[NREG-1:0];
  assign fmt_ok   = instr[31] & ~instr[30] & (instr[29:28] == 2'b00);

  always_comb begin
    unique case (op)
      OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_MIN, OP_MAX, OP_MUL, OP_MULHU, OP_MULHS, OP_ABS,
      OP_SHIFT, OP_ROT, OP_CMPEQ, OP_CMPLT, OP_CMPGT: op_ok = 1'b1;
      default: op_ok = 1'b0;
    endcase
  end

  assign legal     = fmt_ok & op_ok;
  assign mask_zero = (mask == '0);

  // highest selected register: the walk stops there
  always_comb begin
    last_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) last_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/bcast_alu.sv
module bcast_alu
  import bcast_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bop_e              op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SH_LIM = DATA_W;

  logic [2*DATA_W-1:0] prod_u;
  logic [2*DATA_W-1:0] prod_s;
  logic [DATA_W-1:0]   neg_amt;
  logic [DATA_W-1:0]   shl_v;
  logic [DATA_W-1:0]   shr_v;
  logic [SH_W-1:0]     rot_k;
  logic [SH_W:0]       rot_back;
  logic                lt_s;
  logic                gt_s;

  assign prod_u = {{DATA_W{1'b0}}, dst} * {{DATA_W{1'b0}}, src};
  assign prod_s = {{DATA_W{dst[DATA_W-1]}}, dst} * {{DATA_W{src[DATA_W-1]}}, src};

  assign neg_amt = '0 - src;
  assign shl_v   = (src >= SH_LIM) ? '0 : (dst << src[SH_W-1:0]);
  assign shr_v   = (neg_amt >= SH_LIM) ? '0 : (dst >> neg_amt[SH_W-1:0]);

  // a right rotate by n equals a left rotate by -n modulo the width
  assign rot_k    = src[SH_W-1:0];
  assign rot_back = (SH_W+1)'(DATA_W) - {1'b0, rot_k};

  assign lt_s = $signed(dst) < $signed(src);
  assign gt_s = $signed(dst) > $signed(src);

  always_comb begin
    unique case (op)
      OP_MOV:   res = src;
      OP_ADD:   res = dst + src;
      OP_SUB:   res = dst - src;
      OP_AND:   res = dst & src;
      OP_OR:    res = dst | src;
      OP_XOR:   res = dst ^ src;
      OP_MIN:   res = lt_s ? dst : src;
      OP_MAX:   res = gt_s ? dst : src;
      OP_MUL:   res = prod_u[DATA_W-1:0];
      OP_MULHU: res = prod_u[2*DATA_W-1:DATA_W];
      OP_MULHS: res = prod_s[2*DATA_W-1:DATA_W];
      OP_ABS:   res = dst[DATA_W-1] ? ('0 - dst) : dst;
      OP_SHIFT: res = src[DATA_W-1] ? shr_v : shl_v;
      OP_ROT:   res = (dst << rot_k) | (dst >> rot_back);
      OP_CMPEQ: res = (dst == src) ? '1 : '0;
      OP_CMPLT: res = lt_s ? '1 : '0;
      OP_CMPGT: res = gt_s ? '1 : '0;
      default:  res = dst;
    endcase
  end

endmodule

// File: rtl/mask_bcast_unit.sv
module mask_bcast_unit
  import bcast_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  output logic              rd_sel,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              illegal
);

  logic             dec_legal;
  bop_e             dec_op;
  logic             dec_dst_addr;
  logic [IDX_W-1:0] dec_src;
  logic [NREG-1:0]  dec_mask;
  logic             dec_mask_zero;
  logic [IDX_W-1:0] dec_last;

  bst_e              state;
  bop_e              op_q;
  logic              dst_addr_q;
  logic [NREG-1:0]   mask_q;
  logic [IDX_W-1:0]  last_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] alu_res;

  bcast_decode #(.NREG(NREG)) u_dec (
    .instr     (instr),
    .legal     (dec_legal),
    .op        (dec_op),
    .dst_addr  (dec_dst_addr),
    .src_idx   (dec_src),
    .mask      (dec_mask),
    .mask_zero (dec_mask_zero),
    .last_idx  (dec_last)
  );

  bcast_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op_q),
    .dst (rd_data),
    .src (src_q),
    .res (alu_res)
  );

  // rd_idx doubles as the walk cursor once the source has been captured
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_MOV;
      dst_addr_q <= 1'b0;
      mask_q     <= '0;
      last_q     <= '0;
      src_q      <= '0;
      rd_sel     <= 1'b0;
      rd_idx     <= '0;
      wr_en      <= 1'b0;
      wr_sel     <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      wr_en   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (!dec_legal) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else if (dec_mask_zero) begin
              done <= 1'b1;
            end else begin
              busy       <= 1'b1;
              state      <= ST_SRC;
              op_q       <= dec_op;
              dst_addr_q <= dec_dst_addr;
              mask_q     <= dec_mask;
              last_q     <= dec_last;
              rd_sel     <= 1'b0;
              rd_idx     <= dec_src;
            end
          end
        end
        ST_SRC: begin
          src_q  <= rd_data;
          rd_sel <= dst_addr_q;
          rd_idx <= '0;
          state  <= ST_WALK;
        end
        ST_WALK: begin
          wr_en   <= mask_q[rd_idx];
          wr_sel  <= dst_addr_q;
          wr_idx  <= rd_idx;
          wr_data <= alu_res;
          if (rd_idx == last_q) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_illegal_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !wr_en));

  assert_cmp_full_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op_q == OP_CMPEQ || op_q == OP_CMPLT || op_q == OP_CMPGT))
      |-> (wr_data == '0 || wr_data == '1));

  assert_unselected_untouched_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> mask_q[wr_idx]);

  assert_zero_mask_quick_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && dec_legal && dec_mask_zero)
      |=> (done && !illegal && !wr_en));

  assert_walk_ascending_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + 1'b1));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

// File: tb/mask_bcast_unit_bench.sv
module mask_bcast_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  typedef struct packed {
    logic [6:0]  op;
    logic [31:0] s;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{7'd1,  32'h12345678, 32'hAAAAAAAA, 32'h12345678},
    '{7'd2,  32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    '{7'd3,  32'h00000005, 32'h00000003, 32'hFFFFFFFE},
    '{7'd4,  32'h0F0F0F0F, 32'hFF00FF00, 32'h0F000F00},
    '{7'd5,  32'h0F0F0F0F, 32'hFF00FF00, 32'hFF0FFF0F},
    '{7'd6,  32'h0F0F0F0F, 32'hFF00FF00, 32'hF00FF00F},
    '{7'd13, 32'hFFFFFFFF, 32'h00000005, 32'hFFFFFFFF},
    '{7'd14, 32'hFFFFFFFF, 32'h00000005, 32'h00000005},
    '{7'd14, 32'h00000003, 32'h80000000, 32'h00000003},
    '{7'd17, 32'h00010000, 32'h00030001, 32'h00010000},
    '{7'd18, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},
    '{7'd18, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},
    '{7'd19, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    '{7'd19, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF},
    '{7'd20, 32'h00000000, 32'hFFFFFFF6, 32'h0000000A},
    '{7'd21, 32'h00000004, 32'h000000F1, 32'h00000F10},
    '{7'd21, 32'hFFFFFFFC, 32'h80000000, 32'h08000000},
    '{7'd21, 32'h00000020, 32'h00000001, 32'h00000000},
    '{7'd22, 32'h00000004, 32'hF0000001, 32'h0000001F},
    '{7'd22, 32'hFFFFFFFC, 32'h0000001F, 32'hF0000001},
    '{7'd23, 32'h00000007, 32'h00000007, 32'hFFFFFFFF},
    '{7'd23, 32'h00000007, 32'h00000008, 32'h00000000},
    '{7'd24, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{7'd24, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    '{7'd25, 32'h00000001, 32'hFFFFFFFF, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        rd_sel;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_en;
  logic        wr_sel;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        busy;
  logic        done;
  logic        illegal;

  logic [31:0] dreg [16];
  logic [31:0] areg [16];
  logic [31:0] load_d [16];
  logic [31:0] load_a [16];
  logic        load_en = 1'b0;
  int          wr_count = 0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_bcast_unit u_mask_bcast_unit (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .instr   (instr),
    .rd_sel  (rd_sel),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  assign rd_data = rd_sel ? areg[rd_idx] : dreg[rd_idx];

  always @(posedge clk) begin
    if (load_en) begin
      dreg <= load_d;
      areg <= load_a;
    end else if (wr_en) begin
      wr_count <= wr_count + 1;
      if (wr_sel) areg[wr_idx] <= wr_data;
      else        dreg[wr_idx] <= wr_data;
    end
  end

  function automatic logic [31:0] mk(input logic ad, input logic [6:0] op,
                                     input logic [3:0] src, input logic [15:0] m);
    return {1'b1, 1'b0, 2'b00, ad, op, src, m};
  endfunction

  function automatic string tag_of(input logic [6:0] op);
    if (op <= 7'd6) return "R2";
    if (op == 7'd13 || op == 7'd14) return "R3";
    if (op >= 7'd17 && op <= 7'd19) return "R4";
    if (op == 7'd20) return "R5";
    if (op == 7'd21) return "R6";
    if (op == 7'd22) return "R7";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload();
    @(negedge clk);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic fill_default();
    for (int i = 0; i < 16; i++) begin
      load_d[i] = 32'h5A5A0000 + i;
      load_a[i] = 32'hA0A00000 + i;
    end
  endtask

  // edges counts rising edges from the one that samples start to the one raising done
  task automatic run(input logic [31:0] w, output int edges, output bit ill,
                     output int writes, output bit busy_ok);
    int w0;
    w0 = wr_count;
    busy_ok = 1'b1;
    instr = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 100) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      edges++;
    end
    ill = illegal;
    @(negedge clk);
    writes = wr_count - w0;
  endtask

  initial begin
    int edges;
    int writes;
    bit ill;
    bit bok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(!busy && !done && !wr_en && !illegal, "R12",
        {28'd0, busy, done, wr_en, illegal}, 32'd0);

    // vector table: source in data reg 15, mask 0x0F0E
    for (int v = 0; v < NVEC; v++) begin
      bit ok;
      logic [31:0] act;
      logic [31:0] exp;
      fill_default();
      for (int i = 0; i < 16; i++) if (i inside {1,2,3,8,9,10,11}) load_d[i] = VEC[v].d;
      load_d[15] = VEC[v].s;
      preload();
      run(mk(1'b0, VEC[v].op, 4'd15, 16'h0F0E), edges, ill, writes, bok);
      ok = !ill && (writes == 7);
      act = 32'(writes);
      exp = 32'd7;
      for (int i = 0; i < 16; i++) begin
        logic [31:0] want;
        want = (i inside {1,2,3,8,9,10,11}) ? VEC[v].e : load_d[i];
        if (ok && dreg[i] !== want) begin ok = 1'b0; act = dreg[i]; exp = want; end
        if (ok && areg[i] !== load_a[i]) begin ok = 1'b0; act = areg[i]; exp = load_a[i]; end
      end
      chk(ok, tag_of(VEC[v].op), act, exp);
    end

    // R10: zero mask ends after the start edge with no write
    fill_default();
    preload();
    run(mk(1'b0, 7'd2, 4'd3, 16'h0000), edges, ill, writes, bok);
    chk(edges == 1 && !ill, "R10", 32'(edges), 32'd1);
    chk(writes == 0 && dreg[0] == 32'h5A5A0000, "R10", 32'(writes), 32'd0);

    // R1: reserved opcode, then a word with bit 30 set
    run(mk(1'b0, 7'd7, 4'd0, 16'hFFFF), edges, ill, writes, bok);
    chk(ill && edges == 1, "R1", {31'd0, ill}, 32'd1);
    chk(writes == 0, "R1", 32'(writes), 32'd0);
    run(mk(1'b0, 7'd1, 4'd0, 16'hFFFF) | 32'h40000000, edges, ill, writes, bok);
    chk(ill && writes == 0, "R1", 32'(writes), 32'd0);
    run(mk(1'b0, 7'd0, 4'd0, 16'h0001), edges, ill, writes, bok);
    chk(ill && writes == 0 && dreg[0] == 32'h5A5A0000, "R1", dreg[0], 32'h5A5A0000);

    // R11: source reg 2 inside the mask 0x000F
    fill_default();
    load_d[0] = 32'd10; load_d[1] = 32'd20; load_d[2] = 32'd30; load_d[3] = 32'd40;
    preload();
    run(mk(1'b0, 7'd2, 4'd2, 16'h000F), edges, ill, writes, bok);
    chk(dreg[2] == 32'd60, "R11", dreg[2], 32'd60);
    chk(dreg[3] == 32'd70, "R11", dreg[3], 32'd70);

    // R9 + R12: address bank, mask 0x8001, source data reg 4
    fill_default();
    load_d[4] = 32'hCAFEF00D;
    preload();
    run(mk(1'b1, 7'd1, 4'd4, 16'h8001), edges, ill, writes, bok);
    chk(areg[0] == 32'hCAFEF00D && areg[15] == 32'hCAFEF00D, "R9", areg[15], 32'hCAFEF00D);
    chk(areg[7] == 32'hA0A00007 && dreg[0] == 32'h5A5A0000 && dreg[15] == 32'h5A5A000F,
        "R9", areg[7], 32'hA0A00007);
    chk(edges == 18, "R12", 32'(edges), 32'd18);
    chk(writes == 2 && bok && !busy, "R12", 32'(writes), 32'd2);

    // R12: highest bit 2 ends at edge 5
    run(mk(1'b0, 7'd4, 4'd0, 16'h0004), edges, ill, writes, bok);
    chk(edges == 5 && writes == 1, "R12", 32'(edges), 32'd5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R12 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule